// File: doc/BRIEF.md
# Sequential Coefficient Table Loader

This block keeps a table of filter coefficients (128 entries of 16 bits by default) behind a small register bus. Software loads the whole table through one data register. Each write lands at an internal write pointer that steps forward by one. Software reads the table back through the same register, using a separate read pointer that also steps forward. A control register carries a write-enable bit, a feature-enable bit that is passed to the filter datapath, and a read-only flag that reports a completed load.

Each pointer is rewound by one edge of the write-enable bit. Setting the bit opens a load: the write pointer returns to entry 0 and the load-complete flag clears. Clearing the bit closes the load: the read pointer returns to entry 0. While a load is open, reading the data register returns the last value written to it, not a table entry.

A filter datapath fetches coefficients through a separate random-access port by tap index. This port does not use or move either bus pointer.

Top module: `coef_seq_loader`

## Requirements
- R1: The data register is at word address 0 and the control register at word address 1. Bus read data is registered: it appears the cycle after the read strobe and holds until the next read strobe. A data read carries the coefficient in bits 15:0, and bits 31:16 read as zero.
- R2: A data-register write while write-enable is 0 changes neither the table nor the write pointer.
- R3: Writing write-enable from 0 to 1 clears the write pointer and the load-complete flag. Each accepted write then stores at the pointer and advances it, so entries fill in order from 0.
- R4: While write-enable is 1, a data read returns the value most recently written to the data register (zero-extended) and does not move the read pointer.
- R5: Writing write-enable from 1 to 0 clears the read pointer. Each later data read with write-enable at 0 returns the next entry, starting at entry 0.
- R6: The control register has bit 0 = feature enable, bit 1 = write-enable and bit 2 = load-complete (read-only). All other bits read as zero. Output `filt_en` follows bit 0.
- R7: Load-complete becomes 1 when the 128th write of a load is accepted. It stays 0 after a shorter load.
- R8: Writes after the 128th accepted write of a load are discarded and do not wrap over entry 0.
- R9: After a data read returns entry 127, the next data read returns entry 0.
- R10: Reads of the control register or of an unmapped address do not move the read pointer. An unmapped address reads as zero.
- R11: `tap_coef` presents the entry selected by `tap_idx` one clock after the index is applied.
- R12: A synchronous active-high reset clears the control bits, the load-complete flag, both pointers, the last-written value and the bus read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tap_idx | input | 7 | Datapath coefficient index |
| tap_coef | output | 16 | Coefficient at `tap_idx`, one cycle later |
| filt_en | output | 1 | Feature-enable bit of the control register |

## Verification
Every result is due one clock after its cause. Read data, pointer changes, the load-complete flag and `tap_coef` all appear at the rising edge that follows the strobe, the control write or the index change. The bench applies inputs on a falling edge and holds them across one rising edge. It samples at the next falling edge, which is exactly one register stage later. Table contents come from an arithmetic pattern computed in the bench. Full sweeps over all entries, through both the bus and the tap port, compare every entry against that pattern.

// File: rtl/coef_pkg.sv
package coef_pkg;
   // word addresses on the register bus
   localparam int ADDR_DATA = 0;
   localparam int ADDR_CTRL = 1;
   // control register bit positions
   localparam int BIT_EN    = 0;
   localparam int BIT_WREN  = 1;
   localparam int BIT_DONE  = 2;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_HOLD = 2'd1,
      SRC_TAB  = 2'd2
   } rd_src_t;
endpackage

// File: rtl/coef_ctl_regs.sv
module coef_ctl_regs (
   input  logic clk,
   input  logic rst,
   input  logic ctl_wr,
   input  logic new_en,
   input  logic new_wren,
   output logic en,
   output logic wren,
   output logic wren_rise,
   output logic wren_fall
);
   always_ff @(posedge clk) begin
      if (rst) begin
         en   <= 1'b0;
         wren <= 1'b0;
      end else if (ctl_wr) begin
         en   <= new_en;
         wren <= new_wren;
      end
   end

   // edges seen at the moment of the control write
   assign wren_rise = ctl_wr &  new_wren & ~wren;
   assign wren_fall = ctl_wr & ~new_wren &  wren;
endmodule

// File: rtl/coef_ptr_unit.sv
module coef_ptr_unit #(
   parameter int DEPTH = 128,
   parameter int CW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wren,
   input  logic          wren_rise,
   input  logic          wren_fall,
   input  logic          data_wr,
   input  logic          data_rd,
   input  logic [CW-1:0] wdata,
   output logic [IW:0]   wr_cnt,
   output logic [IW-1:0] rd_ptr,
   output logic          wr_acc,
   output logic          tab_re,
   output logic [CW-1:0] last,
   output logic          done
);
   localparam logic [IW:0] FULL = (IW+1)'(DEPTH);
   localparam logic [IW:0] LAST = (IW+1)'(DEPTH - 1);

   assign wr_acc = data_wr & wren & (wr_cnt < FULL);
   assign tab_re = data_rd & ~wren;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_cnt <= '0;
         done   <= 1'b0;
      end else if (wren_rise) begin
         wr_cnt <= '0;
         done   <= 1'b0;
      end else if (wr_acc) begin
         wr_cnt <= wr_cnt + 1'b1;
         if (wr_cnt == LAST) done <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                  last <= '0;
      else if (data_wr && wren) last <= wdata;
   end

   // read pointer wraps naturally (DEPTH is a power of two)
   always_ff @(posedge clk) begin
      if (rst)            rd_ptr <= '0;
      else if (wren_fall) rd_ptr <= '0;
      else if (tab_re)    rd_ptr <= rd_ptr + 1'b1;
   end
endmodule

// File: rtl/coef_table.sv
module coef_table #(
   parameter int DEPTH = 128,
   parameter int CW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [CW-1:0] wdata,
   input  logic          re_a,
   input  logic [IW-1:0] addr_a,
   output logic [CW-1:0] qa,
   input  logic [IW-1:0] addr_b,
   output logic [CW-1:0] qb
);
   logic [CW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re_a) qa <= mem[addr_a];
   end

   always_ff @(posedge clk) begin
      qb <= mem[addr_b];
   end
endmodule

// File: rtl/coef_seq_loader.sv
module coef_seq_loader
   import coef_pkg::*;
#(
   parameter int DEPTH  = 128,
   parameter int CW     = 16,
   parameter int BUS_W  = 32,
   parameter int AW     = 4,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [IW-1:0]    tap_idx,
   output logic [CW-1:0]    tap_coef,
   output logic             filt_en
);
   initial begin
      if ((1 << IW) != DEPTH) $fatal(1, "DEPTH must be a power of two");
      if (BUS_W < CW || BUS_W < 3) $fatal(1, "BUS_W too narrow");
      if ((1 << AW) <= ADDR_CTRL) $fatal(1, "AW too narrow");
   end

   logic hit_data, hit_ctrl;
   logic data_wr, data_rd, ctl_wr;
   assign hit_data = (bus_addr == AW'(ADDR_DATA));
   assign hit_ctrl = (bus_addr == AW'(ADDR_CTRL));
   assign data_wr  = bus_wr & hit_data;
   assign data_rd  = bus_rd & hit_data;
   assign ctl_wr   = bus_wr & hit_ctrl;

   logic wren_q, wren_rise, wren_fall;
   coef_ctl_regs u_ctl (
      .clk      (clk),
      .rst      (rst),
      .ctl_wr   (ctl_wr),
      .new_en   (bus_wdata[BIT_EN]),
      .new_wren (bus_wdata[BIT_WREN]),
      .en       (filt_en),
      .wren     (wren_q),
      .wren_rise(wren_rise),
      .wren_fall(wren_fall)
   );

   logic [IW:0]   wr_cnt;
   logic [IW-1:0] rd_ptr;
   logic          wr_acc, tab_re, done_q;
   logic [CW-1:0] last_q;
   coef_ptr_unit #(.DEPTH(DEPTH), .CW(CW)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .wren     (wren_q),
      .wren_rise(wren_rise),
      .wren_fall(wren_fall),
      .data_wr  (data_wr),
      .data_rd  (data_rd),
      .wdata    (bus_wdata[CW-1:0]),
      .wr_cnt   (wr_cnt),
      .rd_ptr   (rd_ptr),
      .wr_acc   (wr_acc),
      .tab_re   (tab_re),
      .last     (last_q),
      .done     (done_q)
   );

   logic [CW-1:0] tab_q;
   coef_table #(.DEPTH(DEPTH), .CW(CW)) u_tab (
      .clk   (clk),
      .we    (wr_acc),
      .waddr (wr_cnt[IW-1:0]),
      .wdata (bus_wdata[CW-1:0]),
      .re_a  (tab_re),
      .addr_a(rd_ptr),
      .qa    (tab_q),
      .addr_b(tap_idx),
      .qb    (tap_coef)
   );

   // zero extension of coefficient-wide values onto the bus
   logic [BUS_W-1:0] last_ext, tab_ext;
   generate
      if (BUS_W > CW) begin : g_ext
         assign last_ext = {{(BUS_W-CW){1'b0}}, last_q};
         assign tab_ext  = {{(BUS_W-CW){1'b0}}, tab_q};
      end else begin : g_same
         assign last_ext = last_q;
         assign tab_ext  = tab_q;
      end
   endgenerate

   logic [BUS_W-1:0] ctrl_word;
   always_comb begin
      ctrl_word           = '0;
      ctrl_word[BIT_EN]   = filt_en;
      ctrl_word[BIT_WREN] = wren_q;
      ctrl_word[BIT_DONE] = done_q;
   end

   rd_src_t          src_q;
   logic [BUS_W-1:0] hold_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         src_q  <= SRC_ZERO;
         hold_q <= '0;
      end else if (bus_rd) begin
         if (hit_data && !wren_q) begin
            src_q <= SRC_TAB;
         end else if (hit_data) begin
            src_q  <= SRC_HOLD;
            hold_q <= last_ext;
         end else if (hit_ctrl) begin
            src_q  <= SRC_HOLD;
            hold_q <= ctrl_word;
         end else begin
            src_q  <= SRC_ZERO;
         end
      end
   end

   always_comb begin
      unique case (src_q)
         SRC_TAB:  bus_rdata = tab_ext;
         SRC_HOLD: bus_rdata = hold_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/coef_seq_loader_chk.sv
module coef_seq_loader_chk #(
   parameter int DEPTH = 128,
   localparam int IW   = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [3:0]    bus_addr,
   input logic          wren_q,
   input logic          wren_rise,
   input logic          wren_fall,
   input logic          wr_acc,
   input logic          done_q,
   input logic [IW:0]   wr_cnt,
   input logic [IW-1:0] rd_ptr
);
   localparam logic [IW:0] FULL = (IW+1)'(DEPTH);
   localparam logic [IW:0] LAST = (IW+1)'(DEPTH - 1);

   p_ignored_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 4'd0 && !wren_q) |=> $stable(wr_cnt));

   p_wptr_clear_r3: assert property (@(posedge clk) disable iff (rst)
      wren_rise |=> (wr_cnt == '0 && !done_q));

   p_rptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && wren_q) |=> $stable(rd_ptr));

   p_rptr_clear_r5: assert property (@(posedge clk) disable iff (rst)
      wren_fall |=> (rd_ptr == '0));

   p_done_set_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_acc && wr_cnt == LAST) |=> done_q);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      wr_cnt <= FULL);

   p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_cnt == FULL && !wren_rise) |=> (wr_cnt == FULL));

   p_ctrl_noside_r10: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr != 4'd0 && !wren_fall) |=> $stable(rd_ptr));
endmodule

bind coef_seq_loader coef_seq_loader_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .wren_q   (wren_q),
   .wren_rise(wren_rise),
   .wren_fall(wren_fall),
   .wr_acc   (wr_acc),
   .done_q   (done_q),
   .wr_cnt   (wr_cnt),
   .rd_ptr   (rd_ptr)
);

// File: tb/coef_seq_loader_tb.sv
module coef_seq_loader_tb;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  tap_idx = '0;
   logic [15:0] tap_coef;
   logic        filt_en;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   coef_seq_loader u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tap_idx(tap_idx), .tap_coef(tap_coef), .filt_en(filt_en)
   );

   function automatic logic [15:0] cf(input int i, input int s);
      return 16'((i * 40503 + s * 7919 + 3) & 32'hFFFF);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12 reset state
      check("R12 rdata after reset", bus_rdata, 32'h0);
      check("R12 filt_en after reset", {31'b0, filt_en}, 32'h0);
      bread(4'd1, r);
      check("R12 ctrl after reset", r, 32'h0);

      // open a load: wren=1, en=1
      bwrite(4'd1, 32'h3);
      bread(4'd1, r);
      check("R6 ctrl wren+en", r, 32'h3);
      check("R6 filt_en", {31'b0, filt_en}, 32'h1);

      for (int i = 0; i < DEPTH; i++) begin
         bwrite(4'd0, {16'hABCD, cf(i, 1)});
         if (i == DEPTH - 2) begin
            bread(4'd1, r);
            check("R7 done low before last write", r, 32'h3);
         end
      end
      bread(4'd1, r);
      check("R7 done after 128 writes", r, 32'h7);
      bread(4'd0, r);
      check("R4 read returns last written", r, {16'h0, cf(DEPTH - 1, 1)});
      bwrite(4'd0, 32'h0000_5A5A);   // overflow write (R8)
      bread(4'd0, r);
      check("R4 last written after overflow", r, 32'h0000_5A5A);

      // close the load
      bwrite(4'd1, 32'h1);
      bread(4'd1, r);
      check("R6 ctrl done kept, wren low", r, 32'h5);
      for (int i = 0; i < DEPTH; i++) begin
         bread(4'd0, r);
         if (i == 0) check("R8 entry 0 not overwritten", r, {16'h0, cf(0, 1)});
         else        check("R5 sequential read / R1 upper zero", r, {16'h0, cf(i, 1)});
         if (i == 64) begin
            bread(4'd1, r);
            check("R10 ctrl read mid-sweep", r, 32'h5);
         end
      end
      bread(4'd0, r);
      check("R9 read wraps to entry 0", r, {16'h0, cf(0, 1)});

      // partial second load
      bwrite(4'd1, 32'h3);
      bread(4'd1, r);
      check("R3 done cleared on new load", r, 32'h3);
      for (int i = 0; i < 10; i++) bwrite(4'd0, {16'h0, cf(i, 2)});
      bwrite(4'd1, 32'h1);
      bread(4'd1, r);
      check("R7 done low after short load", r, 32'h1);
      bwrite(4'd0, 32'h0000_F00D);   // ignored (R2)
      for (int i = 0; i < DEPTH; i++) begin
         bread(4'd0, r);
         if (i == 10)     check("R2 write with wren low ignored", r, {16'h0, cf(10, 1)});
         else if (i < 10) check("R3 reload from entry 0", r, {16'h0, cf(i, 2)});
         else             check("R5 untouched entries", r, {16'h0, cf(i, 1)});
      end

      // unmapped read, feature disable
      bread(4'd2, r);
      check("R10 unmapped reads zero", r, 32'h0);
      bread(4'd0, r);
      check("R10 pointer unmoved by unmapped read", r, {16'h0, cf(0, 2)});
      bwrite(4'd1, 32'h0);
      bread(4'd1, r);
      check("R6 ctrl cleared", r, 32'h0);
      check("R6 filt_en low", {31'b0, filt_en}, 32'h0);

      // tap port sweep, descending order
      for (int i = DEPTH - 1; i >= 0; i--) begin
         @(negedge clk);
         tap_idx = 7'(i);
         @(negedge clk);
         check("R11 tap port", {16'h0, tap_coef}, {16'h0, (i < 10) ? cf(i, 2) : cf(i, 1)});
      end

      // reset mid-run
      bwrite(4'd1, 32'h3);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check("R12 filt_en after reset", {31'b0, filt_en}, 32'h0);
      bread(4'd1, r);
      check("R12 ctrl after reset", r, 32'h0);

      finish_run();
   end
endmodule